// File: doc/BRIEF.md
# Link-Aggregation Egress Member Selector

This block decides which physical port of a link-aggregation group sends each outgoing frame. A group has at most four members. For each request the block receives a source port number, low-order source and destination address bits, a member-enable mask, the link status of every member and a two-bit balancing mode. It returns the index of the chosen member and a valid flag on the clock edge after the request.

The balancing mode selects the hash key. The key is then reduced modulo the number of members that are both enabled and linked up. It indexes only those live members. When a link drops, the frames that used it spread over the survivors at once. When the link comes back, the same keys map to their original member again. Only the live-member mask is consulted, so no history is kept. If no member is live, the request is not assigned.

Top module: `trunk_port_select`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sel_valid` is 0 and `sel_port` is 0.
- R2: The result is registered. Outputs after clock edge k reflect the inputs sampled at edge k. If `req_valid` was 0 at that edge, `sel_valid` is 0.
- R3: `bal_mode` picks the key. 0 uses `src_port` zero-extended to the address width. 1 uses `src_addr`. 2 uses `dst_addr`. 3 uses `src_addr` XOR `dst_addr`.
- R4: A member is live when its bit is set in both `member_en` and `link_up` (bit i is member i). Whenever `sel_valid` is 1, `sel_port` names a member that was live at the sampling edge.
- R5: Let N be the number of live members, with N greater than 0. The rank is key mod N. `sel_port` is the index of the live member at that rank, counting from 0 at the lowest-numbered live member.
- R6: With no live member, `sel_valid` is 0 on the next edge, even when `req_valid` is 1.
- R7: When all four members are live, `sel_port` equals the two low bits of the key.
- R8: A key that mapped to a member whose link then drops is redirected to a surviving member. Once the link returns, the same key maps to the original member again.
- R9: Whenever `sel_valid` is 0, `sel_port` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A frame requests a member this cycle |
| bal_mode | input | 2 | Balancing mode (key select) |
| src_port | input | SRC_PORT_W | Ingress port of the frame |
| src_addr | input | ADDR_W | Low source address bits |
| dst_addr | input | ADDR_W | Low destination address bits |
| member_en | input | NUM_MEMBERS | Configured group members |
| link_up | input | NUM_MEMBERS | Per-member link status |
| sel_valid | output | 1 | Registered assignment valid |
| sel_port | output | IDX_W | Registered member index |

## Verification
The bench concentrates on three live members, where the reduction is mod 3. A design that masked low key bits instead of taking a true remainder would pick a dead member or skew the spread. It drops a member and brings it back, expecting the original index to return. A design that stored the failover mapping would stay on the backup member. It also sets members that are linked but not enabled, and enabled but down. A design that tested only one of the two bits would send frames to an excluded port. Finally, it clears every live bit while requests keep coming, where a careless design would still raise the valid flag.

// File: rtl/trunk_sel_pkg.sv
package trunk_sel_pkg;

    typedef enum logic [1:0] {
        MODE_SRC_PORT = 2'd0,
        MODE_SRC_ADDR = 2'd1,
        MODE_DST_ADDR = 2'd2,
        MODE_ADDR_XOR = 2'd3
    } bal_mode_e;

endpackage

// File: rtl/trunk_key_mux.sv
module trunk_key_mux
    import trunk_sel_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int SRC_PORT_W = 4
) (
    input  logic [1:0]            mode,
    input  logic [SRC_PORT_W-1:0] src_port,
    input  logic [ADDR_W-1:0]     src_addr,
    input  logic [ADDR_W-1:0]     dst_addr,
    output logic [ADDR_W-1:0]     key
);

    always_comb begin
        case (bal_mode_e'(mode))
            MODE_SRC_PORT: key = ADDR_W'(src_port);
            MODE_SRC_ADDR: key = src_addr;
            MODE_DST_ADDR: key = dst_addr;
            default:       key = src_addr ^ dst_addr;
        endcase
    end

endmodule

// File: rtl/trunk_live_rank.sv
module trunk_live_rank #(
    parameter int NUM_MEMBERS = 4,
    parameter int KEY_W       = 8,
    localparam int IDX_W      = (NUM_MEMBERS > 1) ? $clog2(NUM_MEMBERS) : 1,
    localparam int CNT_W      = $clog2(NUM_MEMBERS + 1)
) (
    input  logic [NUM_MEMBERS-1:0] live,
    input  logic [KEY_W-1:0]       key,
    output logic                   any_live,
    output logic [IDX_W-1:0]       rank
);

    logic [CNT_W-1:0] live_cnt;
    logic [IDX_W-1:0] rem_tab [NUM_MEMBERS];

    // Remainder for every possible group size, each with a constant divisor.
    for (genvar n = 1; n <= NUM_MEMBERS; n++) begin : g_rem
        assign rem_tab[n-1] = IDX_W'(key % KEY_W'(n));
    end

    always_comb begin
        live_cnt = '0;
        for (int i = 0; i < NUM_MEMBERS; i++) begin
            live_cnt = live_cnt + CNT_W'(live[i]);
        end
    end

    always_comb begin
        rank = '0;
        for (int n = 1; n <= NUM_MEMBERS; n++) begin
            if (live_cnt == CNT_W'(n)) rank = rem_tab[n-1];
        end
    end

    assign any_live = (live_cnt != '0);

endmodule

// File: rtl/trunk_nth_member.sv
module trunk_nth_member #(
    parameter int NUM_MEMBERS = 4,
    localparam int IDX_W      = (NUM_MEMBERS > 1) ? $clog2(NUM_MEMBERS) : 1,
    localparam int CNT_W      = $clog2(NUM_MEMBERS + 1)
) (
    input  logic [NUM_MEMBERS-1:0] live,
    input  logic [IDX_W-1:0]       rank,
    output logic [IDX_W-1:0]       port
);

    logic [CNT_W-1:0] seen;

    // Walk the live members from the lowest index and stop at the rank-th one.
    always_comb begin
        seen = '0;
        port = '0;
        for (int i = 0; i < NUM_MEMBERS; i++) begin
            if (live[i]) begin
                if (seen == CNT_W'(rank)) port = IDX_W'(i);
                seen = seen + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/trunk_port_select.sv
module trunk_port_select #(
    parameter int NUM_MEMBERS = 4,
    parameter int ADDR_W      = 8,
    parameter int SRC_PORT_W  = 4,
    localparam int IDX_W      = (NUM_MEMBERS > 1) ? $clog2(NUM_MEMBERS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             bal_mode,
    input  logic [SRC_PORT_W-1:0]  src_port,
    input  logic [ADDR_W-1:0]      src_addr,
    input  logic [ADDR_W-1:0]      dst_addr,
    input  logic [NUM_MEMBERS-1:0] member_en,
    input  logic [NUM_MEMBERS-1:0] link_up,
    output logic                   sel_valid,
    output logic [IDX_W-1:0]       sel_port
);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] port;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [ADDR_W-1:0]      key;
    logic [NUM_MEMBERS-1:0] live;
    logic                   any_live;
    logic [IDX_W-1:0]       rank;
    logic [IDX_W-1:0]       pick;

    assign live = member_en & link_up;

    trunk_key_mux #(
        .ADDR_W    (ADDR_W),
        .SRC_PORT_W(SRC_PORT_W)
    ) u_key (
        .mode    (bal_mode),
        .src_port(src_port),
        .src_addr(src_addr),
        .dst_addr(dst_addr),
        .key     (key)
    );

    trunk_live_rank #(
        .NUM_MEMBERS(NUM_MEMBERS),
        .KEY_W      (ADDR_W)
    ) u_rank (
        .live    (live),
        .key     (key),
        .any_live(any_live),
        .rank    (rank)
    );

    trunk_nth_member #(
        .NUM_MEMBERS(NUM_MEMBERS)
    ) u_pick (
        .live(live),
        .rank(rank),
        .port(pick)
    );

    always_comb begin
        st_d       = '0;
        st_d.valid = req_valid & any_live;
        if (st_d.valid) st_d.port = pick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_valid = st_q.valid;
    assign sel_port  = st_q.port;

endmodule

// File: rtl/trunk_port_select_chk.sv
module trunk_port_select_chk #(
    parameter int NUM_MEMBERS = 4,
    parameter int ADDR_W      = 8,
    parameter int SRC_PORT_W  = 4,
    localparam int IDX_W      = (NUM_MEMBERS > 1) ? $clog2(NUM_MEMBERS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [1:0]             bal_mode,
    input logic [ADDR_W-1:0]      src_addr,
    input logic [ADDR_W-1:0]      dst_addr,
    input logic [NUM_MEMBERS-1:0] member_en,
    input logic [NUM_MEMBERS-1:0] link_up,
    input logic                   sel_valid,
    input logic [IDX_W-1:0]       sel_port
);

    logic [NUM_MEMBERS-1:0] live_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) live_seen_q <= '0;
        else        live_seen_q <= member_en & link_up;
    end

    assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !sel_valid);

    assert_live_req_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (member_en & link_up) != '0) |=> sel_valid);

    assert_pick_is_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> live_seen_q[sel_port]);

    assert_no_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((member_en & link_up) == '0) |=> !sel_valid);

    assert_idle_port_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> sel_port == '0);

    if (NUM_MEMBERS == (1 << IDX_W)) begin : g_pow2
        assert_full_group_xor_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && (member_en & link_up) == '1 && bal_mode == 2'd3)
            |=> sel_port == $past(src_addr[IDX_W-1:0] ^ dst_addr[IDX_W-1:0]));
    end

endmodule

bind trunk_port_select trunk_port_select_chk #(
    .NUM_MEMBERS(NUM_MEMBERS),
    .ADDR_W     (ADDR_W),
    .SRC_PORT_W (SRC_PORT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .bal_mode (bal_mode),
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .member_en(member_en),
    .link_up  (link_up),
    .sel_valid(sel_valid),
    .sel_port (sel_port)
);

// File: tb/trunk_port_select_test.sv
`timescale 1ns/1ps
module trunk_port_select_test;

    localparam int NM  = 4;
    localparam int AW  = 8;
    localparam int SPW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    bal_mode = 2'd0;
    logic [SPW-1:0] src_port = '0;
    logic [AW-1:0] src_addr = '0;
    logic [AW-1:0] dst_addr = '0;
    logic [NM-1:0] member_en = '0;
    logic [NM-1:0] link_up = '0;
    logic          sel_valid;
    logic [1:0]    sel_port;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    trunk_port_select #(.NUM_MEMBERS(NM), .ADDR_W(AW), .SRC_PORT_W(SPW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bal_mode(bal_mode),
        .src_port(src_port), .src_addr(src_addr), .dst_addr(dst_addr),
        .member_en(member_en), .link_up(link_up),
        .sel_valid(sel_valid), .sel_port(sel_port)
    );

    // Expected result from the requirements: {valid, port}.
    function automatic logic [2:0] model(input logic rv, input logic [1:0] m,
                                         input logic [SPW-1:0] sp, input logic [AW-1:0] sa,
                                         input logic [AW-1:0] da, input logic [NM-1:0] en,
                                         input logic [NM-1:0] up);
        logic [AW-1:0] k;
        logic [NM-1:0] lv;
        int cnt, rk, seen;
        case (m)
            2'd0: k = AW'(sp);
            2'd1: k = sa;
            2'd2: k = da;
            default: k = sa ^ da;
        endcase
        lv = en & up;
        cnt = 0;
        for (int i = 0; i < NM; i++) if (lv[i]) cnt++;
        if (!rv || cnt == 0) return 3'b000;
        rk = int'(k) % cnt;
        seen = 0;
        for (int i = 0; i < NM; i++) begin
            if (lv[i]) begin
                if (seen == rk) return {1'b1, 2'(i)};
                seen++;
            end
        end
        return 3'b000;
    endfunction

    task automatic check(input string tag, input logic ev, input logic [1:0] ep);
        n_checks++;
        if (sel_valid !== ev || sel_port !== ep) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b port=%0d, expected valid=%0b port=%0d",
                     tag, sel_valid, sel_port, ev, ep);
        end
    endtask

    // Drive at a falling edge, let one rising edge register it, sample at next falling edge.
    task automatic apply(input logic rv, input logic [1:0] m, input logic [SPW-1:0] sp,
                         input logic [AW-1:0] sa, input logic [AW-1:0] da,
                         input logic [NM-1:0] en, input logic [NM-1:0] up);
        req_valid = rv; bal_mode = m; src_port = sp;
        src_addr = sa; dst_addr = da; member_en = en; link_up = up;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [2:0] e;
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: in reset with a live request pending.
        apply(1'b1, 2'd1, 4'd0, 8'h03, 8'h00, 4'hF, 4'hF);
        check("R1 during reset", 1'b0, 2'd0);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 after reset", 1'b0, 2'd0);

        // R3/R7: each mode with the full group live.
        apply(1'b1, 2'd0, 4'd6, 8'h11, 8'h22, 4'hF, 4'hF);
        check("R3 mode0 src_port 6", 1'b1, 2'd2);
        apply(1'b1, 2'd1, 4'd6, 8'h11, 8'h22, 4'hF, 4'hF);
        check("R3 mode1 src_addr", 1'b1, 2'd1);
        apply(1'b1, 2'd2, 4'd6, 8'h11, 8'h0B, 4'hF, 4'hF);
        check("R3 mode2 dst_addr", 1'b1, 2'd3);
        apply(1'b1, 2'd3, 4'd0, 8'h5A, 8'h0F, 4'hF, 4'hF);
        check("R7 mode3 xor", 1'b1, 2'd1);

        // R2: request withdrawn.
        apply(1'b0, 2'd3, 4'd0, 8'h5A, 8'h0F, 4'hF, 4'hF);
        check("R2 no request", 1'b0, 2'd0);
        check("R9 idle port zero", 1'b0, 2'd0);

        // R8: member 2 drops, key 6 mod 3 = 0 -> member 0, then back to 2.
        apply(1'b1, 2'd0, 4'd6, 8'h00, 8'h00, 4'hF, 4'hB);
        check("R8 failover", 1'b1, 2'd0);
        apply(1'b1, 2'd0, 4'd6, 8'h00, 8'h00, 4'hF, 4'hF);
        check("R8 restore", 1'b1, 2'd2);

        // R5: three live (1,2,3), key 7 mod 3 = 1 -> member 2.
        apply(1'b1, 2'd1, 4'd0, 8'h07, 8'h00, 4'hE, 4'hF);
        check("R5 three live mod3", 1'b1, 2'd2);
        // R5: key 0xFF mod 3 = 0 -> member 1.
        apply(1'b1, 2'd1, 4'd0, 8'hFF, 8'h00, 4'hE, 4'hF);
        check("R5 key ff mod3", 1'b1, 2'd1);

        // R4: enabled-but-down and up-but-disabled are both excluded; only member 2 live.
        apply(1'b1, 2'd2, 4'd0, 8'h00, 8'h03, 4'h5, 4'hE);
        check("R4 single live", 1'b1, 2'd2);

        // R6: nothing live.
        apply(1'b1, 2'd3, 4'd1, 8'h12, 8'h34, 4'h3, 4'hC);
        check("R6 no live member", 1'b0, 2'd0);

        // R5: random stimulus against the model.
        for (int t = 0; t < 3000; t++) begin
            logic rv;
            logic [1:0] m;
            logic [SPW-1:0] sp;
            logic [AW-1:0] sa, da;
            logic [NM-1:0] en, up;
            rv = ($urandom % 8) != 0;
            m  = 2'($urandom);
            sp = SPW'($urandom);
            sa = AW'($urandom);
            da = AW'($urandom);
            en = NM'($urandom);
            up = ($urandom % 3 == 0) ? NM'($urandom) : 4'hF;
            e = model(rv, m, sp, sa, da, en, up);
            apply(rv, m, sp, sa, da, en, up);
            check("R5 random", e[2], e[1:0]);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule